// File: doc/BRIEF.md
# Register Stack Push/Pop Unit

This block carries out the one-byte push and pop instructions of a 32-bit processor. It owns an eight-entry register file and a small byte-addressed stack memory. Entry 4 of the register file serves as the stack pointer. An instruction byte arrives over a valid/ready handshake and is consumed only while the unit is idle. A push moves the pointer down by one word and then stores the selected register there. A pop fetches the word under the pointer into the selected register and then moves the pointer up. The memory port moves one byte per cycle, so each instruction occupies the unit for several cycles. A `busy` level shows the unit is working, and a one-cycle `done` pulse marks the cycle in which the results become visible.

Back-pressure rules: `ins_ready` is high exactly when the unit is idle. A byte transfers on a clock edge where `ins_valid` and `ins_ready` are both high. While `ins_valid` is high and `ins_ready` is low, the producer must hold `ins_op` steady. The register file is preloaded through a plain write port and read through a plain combinational read port. A byte peek port exposes the stack memory.

Top module: `stk_pushpop_unit`

## Requirements
- R1: An opcode whose upper nibble is 0x5 is a stack instruction. Bit 3 clear (0x50 to 0x57) selects push and bit 3 set (0x58 to 0x5F) selects pop. Bits 2:0 give the register index 0 to 7, and index 4 is the stack pointer.
- R2: `ins_ready` is high exactly when `busy` is low. An opcode is consumed on an edge where `ins_valid` and `ins_ready` are both high.
- R3: A push first lowers the stack pointer by 4 and then stores the 32-bit register value at the new pointer. The source register itself is left unchanged.
- R4: A pop reads the 32-bit word at the current stack pointer into the destination register and then raises the stack pointer by 4.
- R5: Words are little-endian. The byte at address SP+k holds bits 8k+7:8k. The memory address is the stack pointer modulo MEM_BYTES, and the pointer register itself wraps modulo 2^32.
- R6: A push of register 4 stores the pointer value from before the decrement.
- R7: A pop into register 4 leaves the loaded word as the final pointer. The +4 adjustment is discarded.
- R8: After a stack opcode is accepted, `busy` stays high for exactly 5 cycles. `done` then pulses for one cycle in the first cycle with `busy` low, and results are readable in that cycle.
- R9: An accepted opcode outside 0x50 to 0x5F is discarded. It raises neither `busy` nor `done` and changes no register or memory byte.
- R10: A register write through `reg_wr_en` takes effect at the next edge only when the unit is idle and no opcode is accepted on that edge. Otherwise it is ignored.
- R11: After reset, all registers and memory bytes read zero, `busy` and `done` are low, and `ins_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Opcode byte is offered |
| ins_ready | output | 1 | Unit is idle and will take the opcode |
| ins_op | input | 8 | One-byte opcode |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| reg_wr_en | input | 1 | Register preload strobe |
| reg_wr_sel | input | 3 | Register preload index |
| reg_wr_data | input | 32 | Register preload value |
| reg_rd_sel | input | 3 | Register read index |
| reg_rd_data | output | 32 | Register read value (combinational) |
| mem_peek_addr | input | $clog2(MEM_BYTES) | Stack memory byte address to observe |
| mem_peek_data | output | 8 | Stack memory byte at that address |

## Verification
Three situations are the hardest to reach from the ports. The first is a register write that arrives while an instruction is still moving bytes. The bench raises `reg_wr_en` on the cycle right after an opcode is accepted, then reads the target register once `done` arrives. The second is a pop whose destination is the stack pointer itself. The bench sets this up by pushing a known word from another register and then popping into index 4, so the loaded word and the incremented pointer differ. The third is pointer wraparound below address zero. The bench starts a push with the pointer at 0, then checks the pointer value and peeks the top bytes of memory.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_REGS  = 8;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int LANES     = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADJ,
    ST_XFER,
    ST_WB
  } stk_state_e;

  // Upper nibble 0x5 marks the push/pop family.
  function automatic logic is_stack_op(input logic [7:0] op);
    return op[7:4] == 4'h5;
  endfunction

  // Bit 3 distinguishes pop (set) from push (clear).
  function automatic logic is_pop_op(input logic [7:0] op);
    return op[3];
  endfunction
endpackage

// File: rtl/stk_regfile.sv
module stk_regfile #(
  parameter int W      = 32,
  parameter int NREG   = 8,
  parameter int SP_IDX = 4,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [IW-1:0] a_sel,
  input  logic [W-1:0]  a_data,
  input  logic          p_we,
  input  logic [W-1:0]  p_data,
  input  logic [IW-1:0] rd0_sel,
  output logic [W-1:0]  rd0_data,
  input  logic [IW-1:0] rd1_sel,
  output logic [W-1:0]  rd1_data,
  output logic [W-1:0]  sp_data
);
  logic [W-1:0] regs [NREG];

  // Port a (data) outranks the pointer port on the same entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (a_we && a_sel == IW'(i))
          regs[i] <= a_data;
        else if (p_we && i == SP_IDX)
          regs[i] <= p_data;
      end
    end
  end

  assign rd0_data = regs[rd0_sel];
  assign rd1_data = regs[rd1_sel];
  assign sp_data  = regs[SP_IDX];
endmodule

// File: rtl/stk_bytemem.sv
module stk_bytemem #(
  parameter int BYTES = 64,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_data
);
  logic [7:0] cells [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) cells[i] <= '0;
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata     = cells[addr];
  assign peek_data = cells[peek_addr];
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW   = 6,
  localparam int LW  = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  input  logic [7:0]           ins_op,
  output logic                 ins_ready,
  output logic                 busy,
  output logic                 done,
  input  logic [WORD_W-1:0]    src_data,
  input  logic [WORD_W-1:0]    sp_data,
  output logic                 rf_a_we,
  output logic [REG_IDX_W-1:0] rf_a_sel,
  output logic [WORD_W-1:0]    rf_a_data,
  output logic                 rf_p_we,
  output logic [WORD_W-1:0]    rf_p_data,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [7:0]           mem_wdata,
  input  logic [7:0]           mem_rdata
);
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

  stk_state_e           state;
  logic [LW-1:0]        lane;
  logic                 pop_q;
  logic [REG_IDX_W-1:0] dst_q;
  logic [WORD_W-1:0]    word_q;
  logic [AW-1:0]        base_q;
  logic                 take;

  assign ins_ready = (state == ST_IDLE);
  assign busy      = !ins_ready;
  assign take      = ins_valid && ins_ready && is_stack_op(ins_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lane   <= '0;
      pop_q  <= 1'b0;
      dst_q  <= '0;
      word_q <= '0;
      base_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            pop_q  <= is_pop_op(ins_op);
            dst_q  <= ins_op[REG_IDX_W-1:0];
            word_q <= src_data;           // pre-decrement value for a push of SP
            base_q <= sp_data[AW-1:0];
            lane   <= '0;
            state  <= is_pop_op(ins_op) ? ST_XFER : ST_ADJ;
          end
        end
        ST_ADJ: begin
          base_q <= base_q - AW'(LANES);
          state  <= ST_XFER;
        end
        ST_XFER: begin
          if (pop_q) word_q[8*lane +: 8] <= mem_rdata;
          lane <= lane + 1'b1;
          if (lane == LAST_LANE) begin
            state <= pop_q ? ST_WB : ST_IDLE;
            done  <= !pop_q;
          end
        end
        ST_WB: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Pointer moves down in ST_ADJ (push) and up in ST_WB (pop).
  assign rf_p_we   = (state == ST_ADJ) || (state == ST_WB);
  assign rf_p_data = (state == ST_ADJ) ? sp_data - WORD_W'(LANES)
                                       : sp_data + WORD_W'(LANES);
  // Destination write shares ST_WB and wins over the pointer update.
  assign rf_a_we   = (state == ST_WB);
  assign rf_a_sel  = dst_q;
  assign rf_a_data = word_q;

  assign mem_we    = (state == ST_XFER) && !pop_q;
  assign mem_addr  = base_q + AW'(lane);
  assign mem_wdata = word_q[8*lane +: 8];
endmodule

// File: rtl/stk_pushpop_unit.sv
module stk_pushpop_unit
  import stk_pkg::*;
#(
  parameter int MEM_BYTES = 64,
  parameter int SP_IDX    = 4,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  output logic                 ins_ready,
  input  logic [7:0]           ins_op,
  output logic                 busy,
  output logic                 done,
  input  logic                 reg_wr_en,
  input  logic [REG_IDX_W-1:0] reg_wr_sel,
  input  logic [WORD_W-1:0]    reg_wr_data,
  input  logic [REG_IDX_W-1:0] reg_rd_sel,
  output logic [WORD_W-1:0]    reg_rd_data,
  input  logic [AW-1:0]        mem_peek_addr,
  output logic [7:0]           mem_peek_data
);
  logic                 seq_a_we;
  logic [REG_IDX_W-1:0] seq_a_sel;
  logic [WORD_W-1:0]    seq_a_data;
  logic                 p_we;
  logic [WORD_W-1:0]    p_data;
  logic [WORD_W-1:0]    src_data;
  logic [WORD_W-1:0]    sp_data;
  logic                 mem_we;
  logic [AW-1:0]        mem_addr;
  logic [7:0]           mem_wdata;
  logic [7:0]           mem_rdata;
  logic                 ext_ok;
  logic                 a_we;
  logic [REG_IDX_W-1:0] a_sel;
  logic [WORD_W-1:0]    a_data;

  // Preload only when idle and no opcode is handed over on the same edge.
  assign ext_ok = reg_wr_en && ins_ready && !ins_valid;
  assign a_we   = seq_a_we || ext_ok;
  assign a_sel  = seq_a_we ? seq_a_sel  : reg_wr_sel;
  assign a_data = seq_a_we ? seq_a_data : reg_wr_data;

  stk_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_op    (ins_op),
    .ins_ready (ins_ready),
    .busy      (busy),
    .done      (done),
    .src_data  (src_data),
    .sp_data   (sp_data),
    .rf_a_we   (seq_a_we),
    .rf_a_sel  (seq_a_sel),
    .rf_a_data (seq_a_data),
    .rf_p_we   (p_we),
    .rf_p_data (p_data),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  stk_regfile #(.W(WORD_W), .NREG(NUM_REGS), .SP_IDX(SP_IDX)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_we     (a_we),
    .a_sel    (a_sel),
    .a_data   (a_data),
    .p_we     (p_we),
    .p_data   (p_data),
    .rd0_sel  (ins_op[REG_IDX_W-1:0]),
    .rd0_data (src_data),
    .rd1_sel  (reg_rd_sel),
    .rd1_data (reg_rd_data),
    .sp_data  (sp_data)
  );

  stk_bytemem #(.BYTES(MEM_BYTES)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (mem_we),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .rdata     (mem_rdata),
    .peek_addr (mem_peek_addr),
    .peek_data (mem_peek_data)
  );
endmodule

// File: rtl/stk_pushpop_chk.sv
module stk_pushpop_chk #(
  parameter int BUSY_CYCLES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_valid,
  input logic       ins_ready,
  input logic [7:0] ins_op,
  input logic       busy,
  input logic       done
);
  logic [7:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_STACK_OP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_op[7:4] == 4'h5) |=> busy); // R1

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ins_ready); // R2

  AST_FOREIGN_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && ins_op[7:4] != 4'h5) |=> (!busy && !done)); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R8

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 8'(BUSY_CYCLES))); // R8
endmodule

bind stk_pushpop_unit stk_pushpop_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .ins_op    (ins_op),
  .busy      (busy),
  .done      (done)
);

// File: tb/stk_pushpop_unit_tb.sv
module stk_pushpop_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 64;
  localparam int AW         = $clog2(MEM_BYTES);
  localparam int N_VEC      = 6;
  localparam int WATCHDOG   = 100000;

  // {opcode, register to inspect, expected value, expected SP}
  localparam logic [74:0] VEC [N_VEC] = '{
    {8'h50, 3'd0, 32'h1122_3344, 32'h0000_002C},
    {8'h51, 3'd1, 32'hA5A5_0001, 32'h0000_0028},
    {8'h5A, 3'd2, 32'hA5A5_0001, 32'h0000_002C},
    {8'h5B, 3'd3, 32'h1122_3344, 32'h0000_0030},
    {8'h54, 3'd4, 32'h0000_002C, 32'h0000_002C},
    {8'h5D, 3'd5, 32'h0000_0030, 32'h0000_0030}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [7:0]    ins_op = '0;
  logic          busy;
  logic          done;
  logic          reg_wr_en = 1'b0;
  logic [2:0]    reg_wr_sel = '0;
  logic [31:0]   reg_wr_data = '0;
  logic [2:0]    reg_rd_sel = '0;
  logic [31:0]   reg_rd_data;
  logic [AW-1:0] mem_peek_addr = '0;
  logic [7:0]    mem_peek_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit ended   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_pushpop_unit #(.MEM_BYTES(MEM_BYTES)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ins_valid     (ins_valid),
    .ins_ready     (ins_ready),
    .ins_op        (ins_op),
    .busy          (busy),
    .done          (done),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_sel    (reg_wr_sel),
    .reg_wr_data   (reg_wr_data),
    .reg_rd_sel    (reg_rd_sel),
    .reg_rd_data   (reg_rd_data),
    .mem_peek_addr (mem_peek_addr),
    .mem_peek_data (mem_peek_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [2:0] sel, output logic [31:0] val);
    reg_rd_sel = sel;
    #1 val = reg_rd_data;
  endtask

  task automatic peek(input int addr, output logic [7:0] val);
    mem_peek_addr = AW'(addr);
    #1 val = mem_peek_data;
  endtask

  task automatic write_reg(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // Offers one opcode on an idle unit, then counts busy cycles until done or timeout.
  task automatic run_op(input logic [7:0] op, output int busy_n, output bit saw_done);
    @(negedge clk);
    ins_valid = 1'b1; ins_op = op;
    @(negedge clk);
    ins_valid = 1'b0;
    busy_n = 0; saw_done = 0;
    for (int k = 0; k < 20; k++) begin
      if (done) begin saw_done = 1; break; end
      if (busy) busy_n++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !ended) begin
      ended = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  b;
    int          bn;
    bit          sd;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    for (int r = 0; r < 8; r++) begin
      read_reg(3'(r), v);
      check("R11 reg reset", v, 32'h0);
    end
    check("R11 busy low", {31'b0, busy}, 32'h0);
    check("R11 done low", {31'b0, done}, 32'h0);
    check("R11 ready high", {31'b0, ins_ready}, 32'h1);
    peek(0, b);
    check("R11 mem reset", {24'b0, b}, 32'h0);

    // R10: preload registers while idle
    write_reg(3'd0, 32'h1122_3344);
    write_reg(3'd1, 32'hA5A5_0001);
    write_reg(3'd4, 32'h0000_0030);
    read_reg(3'd1, v);
    check("R10 idle write", v, 32'hA5A5_0001);

    // Table walk: R1 R3 R4 R6 R8
    for (int i = 0; i < N_VEC; i++) begin
      logic [7:0]  op;
      logic [2:0]  sel;
      logic [31:0] ev, es;
      {op, sel, ev, es} = VEC[i];
      run_op(op, bn, sd);
      check("R8 done seen", {31'b0, sd}, 32'h1);
      check("R8 busy cycles", 32'(bn), 32'd5);
      read_reg(sel, v);
      check(op[3] ? "R4 pop dest" : (sel == 3'd4 ? "R6 push sp" : "R3 push src kept"), v, ev);
      read_reg(3'd4, v);
      check(op[3] ? "R4 sp after pop" : "R3 sp after push", v, es);
    end

    // R5: little-endian layout of 0xA5A50001 at 0x28, SP image at 0x2C
    peek(8'h28, b); check("R5 byte0", {24'b0, b}, 32'h01);
    peek(8'h29, b); check("R5 byte1", {24'b0, b}, 32'h00);
    peek(8'h2A, b); check("R5 byte2", {24'b0, b}, 32'hA5);
    peek(8'h2B, b); check("R5 byte3", {24'b0, b}, 32'hA5);
    peek(8'h2C, b); check("R6 stored old sp", {24'b0, b}, 32'h30);

    // R7: pop into the stack pointer keeps the loaded word
    write_reg(3'd6, 32'h0000_0020);
    write_reg(3'd4, 32'h0000_0010);
    run_op(8'h56, bn, sd);
    read_reg(3'd4, v);
    check("R3 push r6 sp", v, 32'h0000_000C);
    run_op(8'h5C, bn, sd);
    check("R7 done", {31'b0, sd}, 32'h1);
    read_reg(3'd4, v);
    check("R7 pop into sp", v, 32'h0000_0020);

    // R5: wraparound below zero
    write_reg(3'd4, 32'h0000_0000);
    run_op(8'h50, bn, sd);
    read_reg(3'd4, v);
    check("R5 sp wrap", v, 32'hFFFF_FFFC);
    peek(MEM_BYTES - 4, b);
    check("R5 wrap byte0", {24'b0, b}, 32'h44);
    peek(MEM_BYTES - 1, b);
    check("R5 wrap byte3", {24'b0, b}, 32'h11);

    // R9: foreign opcode discarded
    run_op(8'h90, bn, sd);
    check("R9 no busy", 32'(bn), 32'd0);
    check("R9 no done", {31'b0, sd}, 32'h0);
    read_reg(3'd4, v);
    check("R9 sp unchanged", v, 32'hFFFF_FFFC);
    read_reg(3'd0, v);
    check("R9 reg unchanged", v, 32'h1122_3344);

    // R10: register write during busy is ignored; R2 ready low while busy
    @(negedge clk);
    ins_valid = 1'b1; ins_op = 8'h50;
    @(negedge clk);
    ins_valid = 1'b0;
    check("R2 ready low busy", {31'b0, ins_ready}, 32'h0);
    reg_wr_en = 1'b1; reg_wr_sel = 3'd7; reg_wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    reg_wr_en = 1'b0;
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    read_reg(3'd7, v);
    check("R10 busy write ignored", v, 32'h0);

    // R10: write on the same edge as an accepted opcode is ignored
    @(negedge clk);
    ins_valid = 1'b1; ins_op = 8'h90;
    reg_wr_en = 1'b1; reg_wr_sel = 3'd7; reg_wr_data = 32'h0BAD_F00D;
    @(negedge clk);
    ins_valid = 1'b0; reg_wr_en = 1'b0;
    read_reg(3'd7, v);
    check("R10 write with accept ignored", v, 32'h0);

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule